// File: doc/BRIEF.md
# Bus Initiator Transaction Termination Controller

This block runs alongside the initiator side of a bus bridge. It decides in which clock a transaction that the bridge has started on the far bus must end, and it reports why it ended. A transaction begins with a one-cycle start request that carries the transaction kind, the starting address and the latency-timer reload value. From then on the block watches, every clock, for a claim by the target, completed data phases, target stop requests, the prefetch-boundary and last-buffered-word flags from the data path, and the bus grant.

When any ending condition holds, the block drops its frame-active output in the next cycle. In that same cycle it pulses a done strobe with a cause code. A master-abort pulse comes with an unclaimed transaction. A posted write that is cut short by the latency timer also raises a resume request, which carries the DWORD address where the follow-up transaction must begin. All outputs are registered, so every decision appears one clock after the inputs that caused it.

Top module: `init_term_ctl`

## Requirements
- R1: After reset, frame_o, done_o, mabort_o and resume_o are all low.
- R2: An accepted start raises frame_o from the next clock. frame_o stays high until the clock after the ending decision, when done_o pulses for exactly one cycle. A start seen while frame_o is high is ignored.
- R3: If claimed_i is not seen in any of the first five active cycles, the fifth cycle ends the transaction with cause 2 and mabort_o. A claim first seen in the fifth cycle prevents the abort.
- R4: Kinds 0 (delayed write) and 1 (non-prefetchable read) end with cause 1 (normal) on their first completed data phase.
- R5: Kind 2 (prefetchable read) ends with cause 1 on the data phase that carries pf_boundary_i.
- R6: Kinds 3 (posted write) and 4 (memory write and invalidate) end with cause 1 on the data phase that carries buf_last_i.
- R7: The 8-bit latency timer loads lat_init_i at start and counts down once per active clock until it reaches zero. When it is zero and grant_i is low, kinds 2 and 3 end with cause 6. Kind 4 is exempt, and no cut happens while the grant is held.
- R8: A posted write ended by cause 6 pulses resume_o with done_o. resume_addr_o is then the start address plus four times the number of completed data phases, counting the phase completed in the ending cycle.
- R9: A prefetchable read ended by cause 6 does not raise resume_o.
- R10: A stop from a claiming target ends the transaction. With no data phase completed so far, this is cause 3 (retry). Otherwise it is cause 4 (disconnect), whether or not data moves in the stop cycle. A stop without a claim is cause 5 (target abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transaction (sampled while idle) |
| start_kind_i | input | 3 | Transaction kind code 0..4 |
| start_addr_i | input | 32 | Starting DWORD address |
| lat_init_i | input | 8 | Latency timer reload value |
| grant_i | input | 1 | Bus grant still held |
| claimed_i | input | 1 | Target has claimed the transaction |
| xfer_i | input | 1 | A data phase completes this clock |
| stop_i | input | 1 | Target requests stop |
| pf_boundary_i | input | 1 | This data phase reaches a prefetch boundary |
| buf_last_i | input | 1 | This data phase moves the final buffered word |
| frame_o | output | 1 | Initiator frame active |
| done_o | output | 1 | Transaction ended (one-cycle pulse) |
| cause_o | output | 3 | Ending cause, valid with done_o |
| mabort_o | output | 1 | Master abort (one-cycle pulse) |
| resume_o | output | 1 | Posted-write follow-up needed (one-cycle pulse) |
| resume_addr_o | output | 32 | Address of the next undelivered DWORD |

## Verification
The bench sets up a claim in exactly the fifth cycle against no claim at all. An off-by-one in the claim window would either abort a claimed read or let an unclaimed write hang one cycle longer. It tells retry from both forms of disconnect and from target abort, because a design that looked only at the stop cycle would report a retry after data had already moved. Latency cuts are run with the timer reloaded at zero, with the grant dropped after expiry, with the grant held, and for the exempt burst kind. A wrong exemption or a missing grant test shows up as an early end. A resume address that leaves out the ending cycle's phase is four bytes short. The bench also restarts during an active transaction, which must not change the stop rule in force.

// File: rtl/init_term_pkg.sv
package init_term_pkg;

    typedef enum logic [2:0] {
        KIND_DLY_WR  = 3'd0,
        KIND_NP_RD   = 3'd1,
        KIND_PF_RD   = 3'd2,
        KIND_POST_WR = 3'd3,
        KIND_MWI     = 3'd4
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_NORMAL  = 3'd1,
        CAUSE_MABORT  = 3'd2,
        CAUSE_RETRY   = 3'd3,
        CAUSE_DISC    = 3'd4,
        CAUSE_TABORT  = 3'd5,
        CAUSE_LATENCY = 3'd6
    } end_cause_e;

endpackage

// File: rtl/itc_claim_watch.sv
module itc_claim_watch #(
    parameter int WINDOW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic run_i,
    input  logic claimed_i,
    output logic timeout_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } cw_t;

    cw_t q, d;

    always_comb begin
        d = q;
        if (arm_i) begin
            d.cnt  = '0;
            d.seen = 1'b0;
        end else if (run_i) begin
            if (claimed_i) d.seen = 1'b1;
            if (q.cnt != LAST) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign timeout_o = run_i && !q.seen && !claimed_i && (q.cnt == LAST);

    // R3: once the window runs out the owner must close the transaction
    a_r3_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !run_i);

endmodule

// File: rtl/itc_lat_timer.sv
module itc_lat_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LAT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [LAT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                   cnt_d = load_val_i;
        else if (run_i && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R7: one step down per active clock, never wrapping
    a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/itc_stop_rules.sv
module itc_stop_rules
    import init_term_pkg::*;
(
    input  xfer_kind_e kind_i,
    input  logic       had_data_i,
    input  logic       claimed_i,
    input  logic       xfer_i,
    input  logic       stop_i,
    input  logic       pf_boundary_i,
    input  logic       buf_last_i,
    input  logic       expired_i,
    input  logic       grant_i,
    input  logic       timeout_i,
    output end_cause_e cause_o
);
    logic single, can_cut, drains_buf, finished;

    always_comb begin
        single     = (kind_i == KIND_DLY_WR) || (kind_i == KIND_NP_RD);
        can_cut    = (kind_i == KIND_PF_RD)  || (kind_i == KIND_POST_WR);
        drains_buf = (kind_i == KIND_POST_WR) || (kind_i == KIND_MWI);
        finished   = xfer_i && (single
                              || (kind_i == KIND_PF_RD && pf_boundary_i)
                              || (drains_buf && buf_last_i));
        if (stop_i) begin
            if (!claimed_i)                 cause_o = CAUSE_TABORT;
            else if (xfer_i || had_data_i)  cause_o = CAUSE_DISC;
            else                            cause_o = CAUSE_RETRY;
        end else if (finished) begin
            cause_o = CAUSE_NORMAL;
        end else if (can_cut && expired_i && !grant_i) begin
            cause_o = CAUSE_LATENCY;
        end else if (timeout_i) begin
            cause_o = CAUSE_MABORT;
        end else begin
            cause_o = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/init_term_ctl.sv
module init_term_ctl
    import init_term_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LAT_W   = 8,
    parameter int PHASE_W = 12,
    parameter int WINDOW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        start_kind_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LAT_W-1:0]  lat_init_i,
    input  logic              grant_i,
    input  logic              claimed_i,
    input  logic              xfer_i,
    input  logic              stop_i,
    input  logic              pf_boundary_i,
    input  logic              buf_last_i,
    output logic              frame_o,
    output logic              done_o,
    output logic [2:0]        cause_o,
    output logic              mabort_o,
    output logic              resume_o,
    output logic [ADDR_W-1:0] resume_addr_o
);
    localparam int STEP_W = PHASE_W + 2;

    typedef struct packed {
        logic              busy;
        xfer_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [PHASE_W-1:0] phases;
        logic              done;
        end_cause_e        cause;
        logic              mabort;
        logic              resume;
        logic [ADDR_W-1:0] raddr;
    } ctl_t;

    ctl_t q, d;

    logic               accept;
    logic               timeout_w;
    logic               expired_w;
    end_cause_e         cause_w;
    logic [PHASE_W-1:0] phases_inc;
    logic [ADDR_W-1:0]  step;

    assign accept = start_i && !q.busy;

    itc_claim_watch #(.WINDOW(WINDOW)) u_claim (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (accept),
        .run_i     (q.busy),
        .claimed_i (claimed_i),
        .timeout_o (timeout_w)
    );

    itc_lat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (lat_init_i),
        .run_i      (q.busy),
        .expired_o  (expired_w)
    );

    itc_stop_rules u_rules (
        .kind_i        (q.kind),
        .had_data_i    (q.phases != '0),
        .claimed_i     (claimed_i),
        .xfer_i        (xfer_i),
        .stop_i        (stop_i),
        .pf_boundary_i (pf_boundary_i),
        .buf_last_i    (buf_last_i),
        .expired_i     (expired_w),
        .grant_i       (grant_i),
        .timeout_i     (timeout_w),
        .cause_o       (cause_w)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.mabort   = 1'b0;
        d.resume   = 1'b0;
        phases_inc = q.phases + PHASE_W'(xfer_i);
        step       = '0;
        step[STEP_W-1:0] = {phases_inc, 2'b00};
        if (!q.busy) begin
            if (start_i) begin
                d.busy   = 1'b1;
                d.kind   = xfer_kind_e'(start_kind_i);
                d.addr   = start_addr_i;
                d.phases = '0;
            end
        end else begin
            d.phases = phases_inc;
            if (cause_w != CAUSE_NONE) begin
                d.busy   = 1'b0;
                d.done   = 1'b1;
                d.cause  = cause_w;
                d.mabort = (cause_w == CAUSE_MABORT);
                if (cause_w == CAUSE_LATENCY && q.kind == KIND_POST_WR) begin
                    d.resume = 1'b1;
                    d.raddr  = q.addr + step;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign frame_o       = q.busy;
    assign done_o        = q.done;
    assign cause_o       = q.cause;
    assign mabort_o      = q.mabort;
    assign resume_o      = q.resume;
    assign resume_addr_o = q.raddr;

    // R2: the frame only ever drops together with a done pulse
    a_r2_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> done_o);

    // R8: a resume request belongs to a latency cut
    a_r8_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> (done_o && cause_o == CAUSE_LATENCY));

    // R4: single-word kinds finish normally after exactly one phase
    a_r4_one_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cause_o == CAUSE_NORMAL &&
         (q.kind == KIND_DLY_WR || q.kind == KIND_NP_RD)) |-> q.phases == PHASE_W'(1));

    // R10: a retry means no data moved at all
    a_r10_retry_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cause_o == CAUSE_RETRY) |-> q.phases == '0);

endmodule

// File: tb/init_term_ctl_bench.sv
module init_term_ctl_bench;

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] lat;
        logic [4:0] claim;
        logic [4:0] stop;
        logic       sx;
        logic [4:0] last;
        logic [4:0] gdrop;
        logic [4:0] e_end;
        logic [2:0] e_cause;
        logic       e_res;
        logic [7:0] e_ofs;
    } vec_t;

    // kind lat claim stop sx last gdrop | end cause res ofs
    localparam vec_t TBL [16] = '{
        '{3'd0, 8'd50, 5'd2, 5'd0, 1'b0, 5'd0, 5'd0,  5'd2, 3'd1, 1'b0, 8'd0},  // R4
        '{3'd1, 8'd50, 5'd3, 5'd0, 1'b0, 5'd0, 5'd0,  5'd3, 3'd1, 1'b0, 8'd0},  // R4
        '{3'd2, 8'd50, 5'd2, 5'd0, 1'b0, 5'd4, 5'd0,  5'd5, 3'd1, 1'b0, 8'd0},  // R5
        '{3'd3, 8'd50, 5'd1, 5'd0, 1'b0, 5'd3, 5'd0,  5'd3, 3'd1, 1'b0, 8'd0},  // R6
        '{3'd3, 8'd4,  5'd2, 5'd0, 1'b0, 5'd0, 5'd1,  5'd5, 3'd6, 1'b1, 8'd16}, // R7 R8
        '{3'd2, 8'd4,  5'd2, 5'd0, 1'b0, 5'd0, 5'd1,  5'd5, 3'd6, 1'b0, 8'd0},  // R9
        '{3'd4, 8'd4,  5'd2, 5'd0, 1'b0, 5'd8, 5'd1,  5'd9, 3'd1, 1'b0, 8'd0},  // R7 exempt, R6
        '{3'd3, 8'd4,  5'd2, 5'd0, 1'b0, 5'd6, 5'd0,  5'd7, 3'd1, 1'b0, 8'd0},  // R7 grant held
        '{3'd0, 8'd50, 5'd0, 5'd0, 1'b0, 5'd0, 5'd0,  5'd5, 3'd2, 1'b0, 8'd0},  // R3
        '{3'd1, 8'd50, 5'd5, 5'd0, 1'b0, 5'd0, 5'd0,  5'd5, 3'd1, 1'b0, 8'd0},  // R3 edge
        '{3'd3, 8'd50, 5'd2, 5'd2, 1'b0, 5'd0, 5'd0,  5'd2, 3'd3, 1'b0, 8'd0},  // R10 retry
        '{3'd2, 8'd50, 5'd2, 5'd3, 1'b1, 5'd0, 5'd0,  5'd3, 3'd4, 1'b0, 8'd0},  // R10
        '{3'd2, 8'd50, 5'd2, 5'd4, 1'b0, 5'd0, 5'd0,  5'd4, 3'd4, 1'b0, 8'd0},  // R10
        '{3'd3, 8'd50, 5'd0, 5'd3, 1'b0, 5'd0, 5'd0,  5'd3, 3'd5, 1'b0, 8'd0},  // R10 abort
        '{3'd3, 8'd2,  5'd1, 5'd0, 1'b0, 5'd0, 5'd6,  5'd6, 3'd6, 1'b1, 8'd24}, // R7 R8
        '{3'd3, 8'd0,  5'd1, 5'd0, 1'b0, 5'd0, 5'd1,  5'd1, 3'd6, 1'b1, 8'd4}   // R7 R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  start_kind_i = '0;
    logic [31:0] start_addr_i = '0;
    logic [7:0]  lat_init_i = '0;
    logic        grant_i = 1'b1;
    logic        claimed_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        pf_boundary_i = 1'b0;
    logic        buf_last_i = 1'b0;
    logic        frame_o, done_o, mabort_o, resume_o;
    logic [2:0]  cause_o;
    logic [31:0] resume_addr_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    init_term_ctl u_init_term_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_kind_i(start_kind_i),
        .start_addr_i(start_addr_i), .lat_init_i(lat_init_i), .grant_i(grant_i),
        .claimed_i(claimed_i), .xfer_i(xfer_i), .stop_i(stop_i),
        .pf_boundary_i(pf_boundary_i), .buf_last_i(buf_last_i), .frame_o(frame_o),
        .done_o(done_o), .cause_o(cause_o), .mabort_o(mabort_o), .resume_o(resume_o),
        .resume_addr_o(resume_addr_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_i = 1'b0; claimed_i = 1'b0; xfer_i = 1'b0; stop_i = 1'b0;
        pf_boundary_i = 1'b0; buf_last_i = 1'b0; grant_i = 1'b1;
    endtask

    task automatic run_vec(input int idx);
        vec_t v = TBL[idx];
        logic [31:0] base = 32'h0000_1000 + 32'(idx) * 32'h100;
        int n = 0;
        int endc = 0;
        bit frame_bad = 1'b0;
        bit cl, st, x;
        @(negedge clk);
        start_i = 1'b1; start_kind_i = v.kind; start_addr_i = base; lat_init_i = v.lat;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= 20 && endc == 0; k++) begin
            cl = (v.claim != 0) && (k >= int'(v.claim));
            st = (v.stop != 0) && (k == int'(v.stop));
            x  = cl && (!st || v.sx);
            if (x) n++;
            claimed_i = cl; stop_i = st; xfer_i = x;
            pf_boundary_i = x && (v.kind == 3'd2) && (n == int'(v.last));
            buf_last_i    = x && (v.kind != 3'd2) && (n == int'(v.last));
            grant_i = !((v.gdrop != 0) && (k >= int'(v.gdrop)));
            @(negedge clk);
            if (done_o) endc = k;
            else if (!frame_o) frame_bad = 1'b1;
        end
        chk(endc == int'(v.e_end), $sformatf("R2 end cycle vec %0d", idx), endc, v.e_end);
        chk(!frame_bad && !frame_o, $sformatf("R2 frame span vec %0d", idx), frame_o, 0);
        chk(cause_o == v.e_cause, $sformatf("R10 cause vec %0d", idx), cause_o, v.e_cause);
        chk(mabort_o == (v.e_cause == 3'd2), $sformatf("R3 abort flag vec %0d", idx),
            mabort_o, v.e_cause == 3'd2);
        chk(resume_o == v.e_res, $sformatf("R9 resume flag vec %0d", idx), resume_o, v.e_res);
        if (v.e_res)
            chk(resume_addr_o == base + 32'(v.e_ofs), $sformatf("R8 resume addr vec %0d", idx),
                resume_addr_o, base + 32'(v.e_ofs));
        idle_inputs();
        @(negedge clk);
        chk(!done_o && !resume_o, $sformatf("R2 single pulse vec %0d", idx), done_o, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!frame_o && !done_o && !mabort_o && !resume_o, "R1 reset outputs",
            {frame_o, done_o, mabort_o, resume_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!frame_o && !done_o, "R1 idle after release", {frame_o, done_o}, 0);

        for (int i = 0; i < 16; i++) run_vec(i);

        // R2: a start during an active delayed write must not switch its stop rule
        @(negedge clk);
        start_i = 1'b1; start_kind_i = 3'd0; start_addr_i = 32'h2000; lat_init_i = 8'd50;
        @(negedge clk);
        start_kind_i = 3'd3; start_addr_i = 32'h3000;   // still held: ignored
        @(negedge clk);
        start_i = 1'b0; claimed_i = 1'b1; xfer_i = 1'b1;
        @(negedge clk);
        chk(done_o && cause_o == 3'd1, "R2 start ignored while busy (R4 rule kept)",
            {done_o, cause_o}, {1'b1, 3'd1});
        idle_inputs();
        @(negedge clk);
        chk(!frame_o, "R2 frame low after end", frame_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule